// File: doc/BRIEF.md
# Raster Video Timing Generator

This block produces the horizontal and vertical timing for a fixed raster of 384 by 264 pixels. It runs from a master clock at four times the pixel rate. Each scanline is 1536 master clocks long. Each frame is 264 scanlines, which gives about 59.18 frames per second from a 24 MHz master clock. The outputs are:

- active-low horizontal and vertical sync;
- a horizontal blanking flag, which tells the colour path to output the reference backdrop colour (entry 0 of palette 0);
- a vertical blanking flag, which forces the video level to zero;
- a one-cycle pixel strobe;
- the current 9-bit line number, which software can read.

The line number does not start at zero. It runs from 0x0F8 up to 0x1FF and then wraps back to 0x0F8. A mode input selects what happens to the 16 border lines above and below the 224-line picture area. In PAL mode they are shown, giving 256 visible lines. In NTSC mode they are blanked, giving 224 visible lines. After reset is released, the generator holds off for a fixed start-up delay, so that the first rising edge of the horizontal sync output comes at a known clock count.

Top module: `video_timing_gen`

## Requirements
- R1: After start-up, `hsync_n` is low for the first 112 master clocks of every 1536-clock scanline and high for the remaining 1424.
- R2: `hblank` is high for line positions 0 to 223 and 1504 to 1535, and low for the 1280 active positions 224 to 1503. `hblank` is always high while `hsync_n` is low.
- R3: `pix_en` is high on exactly one master clock in four, at line positions that are multiples of 4. Its first active-area strobe falls on the same clock on which `hblank` goes low.
- R4: `line_cnt` advances by one on the clock on which `hsync_n` falls. It wraps from 0x1FF to 0x0F8, so it never holds a value below 0x0F8.
- R5: `vsync_n` is low while `line_cnt` is in 0x0F8 to 0x0FF and high for all other lines.
- R6: `vblank` changes only 56 master clocks after a scanline starts, so it takes the state of the new line at that point. It is 1 for lines 0x0F8 to 0x0FF and 0 for lines 0x110 to 0x1EF.
- R7: For the border lines 0x100 to 0x10F and 0x1F0 to 0x1FF, `vblank` is 1 when the latched mode is NTSC (`mode_pal` = 0) and 0 when the latched mode is PAL (`mode_pal` = 1).
- R8: `mode_pal` is captured only while reset is active and on the wrap from 0x1FF to 0x0F8. A change in the middle of a frame has no effect on that frame.
- R9: While `rst_n` is low at a clock edge, the outputs are: `line_cnt` = 0x0F8, `hsync_n` = 0, `vsync_n` = 0, `hblank` = 1, `vblank` = 1, `pix_en` = 0.
- R10: Counting the first rising clock edge with `rst_n` high as edge 1, `hsync_n` first goes high after edge 1399. `pix_en` first pulses after edge 1287, which is the first clock of the first scanline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, four per pixel |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pal | input | 1 | 1 shows the border lines, 0 blanks them |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| hblank | output | 1 | Horizontal blanking flag (show the reference colour) |
| vblank | output | 1 | Vertical blanking flag (force the output to zero) |
| pix_en | output | 1 | One-clock pixel strobe |
| line_cnt | output | 9 | Current scanline number, 0x0F8 to 0x1FF |

## Verification
The horizontal timing is checked on a default-sized instance. Single clocks are sampled on each side of every edge of the first scanline: the first sync release, the first pixel strobe, the start and end of the active area, and the next line step. This separates an off-by-one error in the start-up delay from one in the line decode. The vertical behaviour is checked on a second instance with a short line. A vector table walks that instance through one NTSC frame and one PAL frame, with `mode_pal` toggled in the middle of each frame. Each vector compares `vblank` just before and just after the 56-clock point, which separates the border policy, the frame-boundary mode capture and the mid-line update. A closing reset with PAL selected confirms that the mode is captured during reset.

// File: rtl/video_timing_pkg.sv
// Shared constants and helpers for the raster timing generator.
// Assumes a fixed 264-line frame whose 9-bit line numbers start at 0x0F8.
package video_timing_pkg;

    localparam int LINE_W       = 9;
    localparam int PIX_DIV      = 4;
    localparam int V_SYNC_LINES = 8;
    localparam int V_TOP_LINES  = 16;
    localparam int V_ACT_LINES  = 224;
    localparam int V_BOT_LINES  = 16;
    localparam int V_TOTAL      = V_SYNC_LINES + V_TOP_LINES + V_ACT_LINES + V_BOT_LINES;

    localparam logic [LINE_W-1:0] LINE_FIRST = 9'h0F8;
    localparam logic [LINE_W-1:0] LINE_LAST  = LINE_W'(int'(LINE_FIRST) + V_TOTAL - 1);
    localparam logic [LINE_W-1:0] TOP_START  = LINE_W'(int'(LINE_FIRST) + V_SYNC_LINES);
    localparam logic [LINE_W-1:0] ACT_START  = LINE_W'(int'(TOP_START) + V_TOP_LINES);
    localparam logic [LINE_W-1:0] BOT_START  = LINE_W'(int'(ACT_START) + V_ACT_LINES);

    typedef enum logic [1:0] {
        VR_SYNC,
        VR_TOP,
        VR_ACTIVE,
        VR_BOTTOM
    } vregion_e;

    // Map a line number onto its vertical region.
    function automatic vregion_e line_region(input logic [LINE_W-1:0] ln);
        if (ln < TOP_START)      return VR_SYNC;
        else if (ln < ACT_START) return VR_TOP;
        else if (ln < BOT_START) return VR_ACTIVE;
        else                     return VR_BOTTOM;
    endfunction

endpackage

// File: rtl/vt_startup.sv
// Start-up hold: counts HOLD clocks after reset release, then raises run.
// Assumes HOLD >= 1. The count saturates, so run stays high until the next reset.
module vt_startup #(
    parameter int HOLD = 1287
) (
    input  logic clk,
    input  logic rst_n,
    output logic run
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt;

    // Saturating hold counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt != CW'(HOLD))
            cnt <= cnt + 1'b1;
    end

    assign run = (cnt == CW'(HOLD));
endmodule

// File: rtl/vt_hcount.sv
// Horizontal position counter over one scanline of H_TOTAL master clocks.
// Position 0 is the first clock of horizontal sync. It produces the line-step
// and the mid-line vertical-blank update strobes. Assumes 1 <= VB_DELAY < H_TOTAL.
module vt_hcount #(
    parameter int H_TOTAL  = 1536,
    parameter int VB_DELAY = 56
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         run,
    output logic [$clog2(H_TOTAL)-1:0]   hpos,
    output logic                         line_adv,
    output logic                         vb_tick
);
    localparam int HW = $clog2(H_TOTAL);

    // Position counter, wrapping at the end of the line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hpos <= '0;
        else if (run)
            hpos <= (hpos == HW'(H_TOTAL - 1)) ? '0 : hpos + 1'b1;
    end

    assign line_adv = run && (hpos == HW'(H_TOTAL - 1));
    assign vb_tick  = run && (hpos == HW'(VB_DELAY - 1));
endmodule

// File: rtl/vt_vcount.sv
// Line counter (0x0F8..0x1FF), frame-boundary mode latch and the vertical
// blanking register. Assumes line_adv and vb_tick never fire on the same clock.
module vt_vcount
    import video_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_adv,
    input  logic              vb_tick,
    input  logic              mode_pal,
    output logic [LINE_W-1:0] line,
    output logic              vblank
);
    logic     pal_q;
    vregion_e region_now;

    assign region_now = line_region(line);

    // Line counter with wrap back to the first sync line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line <= LINE_FIRST;
        else if (line_adv)
            line <= (line == LINE_LAST) ? LINE_FIRST : line + 1'b1;
    end

    // Mode latch: follows the input in reset, then updates only at the frame wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pal_q <= mode_pal;
        else if (line_adv && line == LINE_LAST)
            pal_q <= mode_pal;
    end

    // Vertical blank register, updated partway into each line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vblank <= 1'b1;
        else if (vb_tick) begin
            case (region_now)
                VR_SYNC:   vblank <= 1'b1;
                VR_ACTIVE: vblank <= 1'b0;
                default:   vblank <= !pal_q;
            endcase
        end
    end
endmodule

// File: rtl/video_timing_gen.sv
// Raster timing generator top. It ties together the start-up hold, the
// horizontal counter and the vertical counter, and decodes the sync, blank
// and pixel-strobe outputs from the horizontal position.
// Assumes PIX_DIV divides the porch and active widths.
module video_timing_gen
    import video_timing_pkg::*;
#(
    parameter int H_SYNC     = 112,
    parameter int H_BACK     = 112,
    parameter int H_ACTIVE   = 1280,
    parameter int H_FRONT    = 32,
    parameter int VB_DELAY   = 56,
    parameter int FIRST_SYNC = 1399
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_pal,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              hblank,
    output logic              vblank,
    output logic              pix_en,
    output logic [LINE_W-1:0] line_cnt
);
    localparam int H_TOTAL = H_SYNC + H_BACK + H_ACTIVE + H_FRONT;
    localparam int HW      = $clog2(H_TOTAL);
    localparam int PW      = $clog2(PIX_DIV);
    localparam int HOLD    = FIRST_SYNC - H_SYNC;
    localparam int ACT_BEG = H_SYNC + H_BACK;
    localparam int ACT_END = ACT_BEG + H_ACTIVE;

    logic          run;
    logic [HW-1:0] hpos;
    logic          line_adv;
    logic          vb_tick;

    vt_startup #(.HOLD(HOLD)) u_start (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run)
    );

    vt_hcount #(.H_TOTAL(H_TOTAL), .VB_DELAY(VB_DELAY)) u_hcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .hpos     (hpos),
        .line_adv (line_adv),
        .vb_tick  (vb_tick)
    );

    vt_vcount u_vcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_adv (line_adv),
        .vb_tick  (vb_tick),
        .mode_pal (mode_pal),
        .line     (line_cnt),
        .vblank   (vblank)
    );

    // Horizontal decode: sync, blank and pixel strobe from the position.
    always_comb begin
        hsync_n = run && (hpos >= HW'(H_SYNC));
        hblank  = !run || (hpos < HW'(ACT_BEG)) || (hpos >= HW'(ACT_END));
        pix_en  = run && (hpos[PW-1:0] == '0);
    end

    // Vertical sync from the line region.
    assign vsync_n = (line_region(line_cnt) != VR_SYNC);
endmodule

// File: rtl/vt_checker.sv
// Timing properties for video_timing_gen, attached to it by bind.
module vt_checker
    import video_timing_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              hsync_n,
    input logic              vsync_n,
    input logic              hblank,
    input logic              vblank,
    input logic              pix_en,
    input logic [LINE_W-1:0] line_cnt
);
    AST_SYNC_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> hblank); // R2

    AST_FIRST_PIX: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hblank) |-> pix_en); // R3

    AST_PIX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en |=> !pix_en); // R3

    AST_LINE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        line_cnt >= LINE_FIRST); // R4

    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(line_cnt) |-> (line_cnt == $past(line_cnt) + 1'b1) ||
                               ($past(line_cnt) == LINE_LAST && line_cnt == LINE_FIRST)); // R4

    AST_LINE_AT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(line_cnt) |-> $fell(hsync_n)); // R4

    AST_VSYNC_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!vsync_n && line_cnt != LINE_FIRST) |-> vblank); // R5

    AST_VB_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(vblank) |-> (!hsync_n && hblank)); // R6

    AST_ACTIVE_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (line_cnt > ACT_START && line_cnt < BOT_START) |-> !vblank); // R6
endmodule

bind video_timing_gen vt_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hsync_n  (hsync_n),
    .vsync_n  (vsync_n),
    .hblank   (hblank),
    .vblank   (vblank),
    .pix_en   (pix_en),
    .line_cnt (line_cnt)
);

// File: tb/video_timing_gen_tb.sv
module video_timing_gen_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_pal = 1'b0;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    // Default-sized instance for horizontal and start-up timing.
    logic       hsync_n, vsync_n, hblank, vblank, pix_en;
    logic [8:0] line_cnt;

    video_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .mode_pal(mode_pal),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .hblank(hblank),
        .vblank(vblank), .pix_en(pix_en), .line_cnt(line_cnt)
    );

    // Short-line instance (36 clocks per line) for frame-level checks.
    logic       s_hsync_n, s_vsync_n, s_hblank, s_vblank, s_pix_en;
    logic [8:0] s_line;

    video_timing_gen #(
        .H_SYNC(8), .H_BACK(8), .H_ACTIVE(16), .H_FRONT(4), .VB_DELAY(4), .FIRST_SYNC(1399)
    ) u_small (
        .clk(clk), .rst_n(rst_n), .mode_pal(mode_pal),
        .hsync_n(s_hsync_n), .vsync_n(s_vsync_n), .hblank(s_hblank),
        .vblank(s_vblank), .pix_en(s_pix_en), .line_cnt(s_line)
    );

    typedef struct packed {
        logic [8:0] line;
        logic       drv_pal;
        logic       vs_n;
        logic       vb_old;
        logic       vb_new;
    } vec_t;

    // line, mode driven after the checks, vsync_n, vblank before/after the update point
    localparam vec_t VECS [16] = '{
        '{9'h0FF, 1'b0, 1'b0, 1'b1, 1'b1},
        '{9'h100, 1'b0, 1'b1, 1'b1, 1'b1},
        '{9'h10F, 1'b0, 1'b1, 1'b1, 1'b1},
        '{9'h110, 1'b0, 1'b1, 1'b1, 1'b0},
        '{9'h111, 1'b1, 1'b1, 1'b0, 1'b0},
        '{9'h1EF, 1'b1, 1'b1, 1'b0, 1'b0},
        '{9'h1F0, 1'b1, 1'b1, 1'b0, 1'b1},
        '{9'h1FF, 1'b1, 1'b1, 1'b1, 1'b1},
        '{9'h0F8, 1'b1, 1'b0, 1'b1, 1'b1},
        '{9'h0FF, 1'b1, 1'b0, 1'b1, 1'b1},
        '{9'h100, 1'b1, 1'b1, 1'b1, 1'b0},
        '{9'h110, 1'b0, 1'b1, 1'b0, 1'b0},
        '{9'h1F0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{9'h1FF, 1'b0, 1'b1, 1'b0, 1'b0},
        '{9'h0F8, 1'b0, 1'b0, 1'b0, 1'b1},
        '{9'h100, 1'b0, 1'b1, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_small_line(input logic [8:0] target);
        do @(negedge clk); while (s_line !== target);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (5) @(negedge clk);
        check("R9 line_cnt", 32'(line_cnt), 32'h0F8);
        check("R9 hsync_n", 32'(hsync_n), 0);
        check("R9 vsync_n", 32'(vsync_n), 0);
        check("R9 hblank", 32'(hblank), 1);
        check("R9 vblank", 32'(vblank), 1);
        check("R9 pix_en", 32'(pix_en), 0);
        rst_n = 1'b1;

        // Horizontal timing on the default instance, counted in edges since release.
        for (int k = 1; k <= 2823; k++) begin
            @(negedge clk);
            case (k)
                1286: check("R10 pix_en before start", 32'(pix_en), 0);
                1287: check("R10 first pix_en", 32'(pix_en), 1);
                1288: check("R3 pix_en one in four", 32'(pix_en), 0);
                1291: check("R3 pix_en next strobe", 32'(pix_en), 1);
                1398: check("R10 hsync_n still low", 32'(hsync_n), 0);
                1399: check("R10 hsync_n first rise", 32'(hsync_n), 1);
                1510: check("R2 hblank before active", 32'(hblank), 1);
                1511: begin
                    check("R2 hblank active start", 32'(hblank), 0);
                    check("R3 pix_en at active start", 32'(pix_en), 1);
                end
                2790: check("R2 hblank last active", 32'(hblank), 0);
                2791: check("R2 hblank front porch", 32'(hblank), 1);
                2822: begin
                    check("R1 hsync_n line end", 32'(hsync_n), 1);
                    check("R4 line before step", 32'(line_cnt), 32'h0F8);
                end
                2823: begin
                    check("R1 hsync_n next line", 32'(hsync_n), 0);
                    check("R4 line after step", 32'(line_cnt), 32'h0F9);
                end
                default: ;
            endcase
        end

        // Vector walk on the short-line instance: R5, R6, R7, R8.
        foreach (VECS[i]) begin
            wait_small_line(VECS[i].line);
            check("R5 vsync_n", 32'(s_vsync_n), 32'(VECS[i].vs_n));
            repeat (3) @(negedge clk);
            check("R6 vblank before update", 32'(s_vblank), 32'(VECS[i].vb_old));
            @(negedge clk);
            check("R7 R8 vblank after update", 32'(s_vblank), 32'(VECS[i].vb_new));
            mode_pal = VECS[i].drv_pal;
        end

        // R9 again mid-run, and R8: the mode is captured during reset.
        @(negedge clk);
        mode_pal = 1'b1;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 small line", 32'(s_line), 32'h0F8);
        check("R9 small vblank", 32'(s_vblank), 1);
        check("R9 small hsync_n", 32'(s_hsync_n), 0);
        check("R9 small pix_en", 32'(s_pix_en), 0);
        rst_n = 1'b1;
        wait_small_line(9'h100);
        repeat (4) @(negedge clk);
        check("R8 mode taken in reset", 32'(s_vblank), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule